// File: doc/BRIEF.md
# Four-Phase Symbol Deinterleaver for FSK Pager Frames

This block takes the data-field symbols of a pager frame, one per strobe, and spreads them over four parallel bit streams named phases A, B, C and D. Each symbol is a two-bit level index (0 to 3). The frame's mode selects the symbol rate (normal or double) and the number of levels (two or four). In four-level mode a symbol carries a Gray-coded pair of bits that lands on a pair of phases. At the double rate, consecutive symbols alternate between the A/B pair and the C/D pair. The four bits leave the block together once the second symbol of a pair arrives.

A phase that the mode does not use stays at 0, and the downstream decoder reads 0 as idle. A frame-start input clears every held bit and the even/odd tracking, so bits from one frame's mode never show up in the next frame. Symbol timing, sync detection and error correction happen upstream and downstream of this block.

Top module: `fsk_phase_split`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, all four phase outputs and `grp_vld` are 0. A reset in the middle of a frame clears the even/odd tracking, so the next double-rate symbol is treated as even.
- R2: The first bit of a pair (A for the first pair, C for the second) is 1 for symbols 0 and 1, and 0 for symbols 2 and 3.
- R3: With `quad_lvl`=1, the second bit of a pair (B or D) is 1 for symbols 0 and 3, and 0 for symbols 1 and 2. The full mapping is symbol 0→11, 1→10, 2→00, 3→01 (first bit, second bit).
- R4: With `quad_lvl`=0, the second bit written into a pair is 0, so B and D stay 0.
- R5: With `rate_dbl`=0, every accepted strobe updates A/B. In the cycle after that strobe's clock edge, `grp_vld` is 1. When there is no strobe, `grp_vld` is 0 in the next cycle.
- R6: With `rate_dbl`=0 from frame start onward, C and D stay 0.
- R7: With `rate_dbl`=1, the first symbol after frame start, and every second symbol after it, updates only A/B. After such a symbol, `grp_vld` stays 0 and C/D keep their values.
- R8: With `rate_dbl`=1, the other symbols update C/D and raise `grp_vld` for one cycle. At that point all four phases carry the completed group.
- R9: `frame_start` clears all four phase bits, `grp_vld` and the even/odd tracking on the next edge. It takes priority over a strobe in the same cycle, and that strobe is discarded.
- R10: A cycle with neither strobe nor frame start leaves all four phase outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frame_start | input | 1 | Start of a new frame's data field; clears held state |
| sym_stb | input | 1 | One-cycle strobe: `sym` holds a new symbol |
| sym | input | SYM_W | Symbol level index, 0 to 3 |
| rate_dbl | input | 1 | 1 = double symbol rate (pairs interleaved) |
| quad_lvl | input | 1 | 1 = four-level symbols (two bits per symbol) |
| ph_a | output | 1 | Phase A bit |
| ph_b | output | 1 | Phase B bit |
| ph_c | output | 1 | Phase C bit |
| ph_d | output | 1 | Phase D bit |
| grp_vld | output | 1 | One-cycle pulse: the phase bits form a complete group |

## Verification
The assertions check the following on every cycle:
- `grp_vld` only follows an accepted strobe.
- Frame start empties the outputs.
- Idle cycles keep the phases steady.
- The first bit of a pair follows the level of the symbol that was just taken, at both rates.
- Two-level mode never sets B at the normal rate.

Only the bench's scenarios can show the alternation between pairs at the double rate. The same holds for the full Gray table across all four symbols, C/D staying idle at the normal rate, and a reset in mid-frame sending the next symbol back to the even slot. These depend on the history of symbols since frame start.

// File: rtl/fsk_split_pkg.sv
package fsk_split_pkg;

   // One pair of phase bits: hi is the first phase (A or C), lo the second (B or D)
   typedef struct packed {
      logic hi;
      logic lo;
   } pair_t;

   localparam int NUM_PAIRS = 2;

endpackage

// File: rtl/fsk_sym_demap.sv
module fsk_sym_demap
   import fsk_split_pkg::*;
#(
   parameter int SYM_W = 2
) (
   input  logic [SYM_W-1:0] sym,
   input  logic             quad_lvl,
   output pair_t            bits
);

   // Gray demap: the upper level half gives 0 on the first bit.
   // The outer levels give 1 on the second bit.
   always_comb begin
      bits.hi = ~sym[SYM_W-1];
      bits.lo = quad_lvl & ~(sym[1] ^ sym[0]);
   end

endmodule

// File: rtl/fsk_pair_reg.sv
module fsk_pair_reg
   import fsk_split_pkg::*;
#(
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  clr,
   input  logic  load,
   input  pair_t d,
   output pair_t q
);

   pair_t q_nxt;

   always_comb begin
      q_nxt = q;
      if (clr)
         q_nxt = '0;
      else if (load)
         q_nxt = d;
   end

   generate
      if (ASYNC_RST) begin : g_arst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= q_nxt;
         end
      end else begin : g_srst
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= q_nxt;
         end
      end
   endgenerate

endmodule

// File: rtl/fsk_group_seq.sv
module fsk_group_seq
   import fsk_split_pkg::*;
#(
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 frame_start,
   input  logic                 sym_stb,
   input  logic                 rate_dbl,
   output logic [NUM_PAIRS-1:0] load,
   output logic                 grp_vld
);

   logic odd_q, odd_nxt;
   logic vld_nxt;
   logic take;

   always_comb begin
      take    = sym_stb & ~frame_start;
      load[0] = take & (~rate_dbl | ~odd_q);
      load[1] = take &   rate_dbl &  odd_q;
      vld_nxt = take & (~rate_dbl | odd_q);
      if (frame_start)  odd_nxt = 1'b0;
      else if (take)    odd_nxt = rate_dbl & ~odd_q;
      else              odd_nxt = odd_q;
   end

   generate
      if (ASYNC_RST) begin : g_arst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               odd_q   <= 1'b0;
               grp_vld <= 1'b0;
            end else begin
               odd_q   <= odd_nxt;
               grp_vld <= vld_nxt;
            end
         end
      end else begin : g_srst
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               odd_q   <= 1'b0;
               grp_vld <= 1'b0;
            end else begin
               odd_q   <= odd_nxt;
               grp_vld <= vld_nxt;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fsk_phase_split.sv
module fsk_phase_split
   import fsk_split_pkg::*;
#(
   parameter int SYM_W     = 2,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_start,
   input  logic             sym_stb,
   input  logic [SYM_W-1:0] sym,
   input  logic             rate_dbl,
   input  logic             quad_lvl,
   output logic             ph_a,
   output logic             ph_b,
   output logic             ph_c,
   output logic             ph_d,
   output logic             grp_vld
);

   generate
      if (SYM_W != 2) begin : g_bad_sym_w
         $error("fsk_phase_split: SYM_W must be 2");
      end
   endgenerate

   pair_t                 demap;
   pair_t                 held [NUM_PAIRS];
   logic [NUM_PAIRS-1:0]  load;

   fsk_sym_demap #(.SYM_W(SYM_W)) demap_i (
      .sym      (sym),
      .quad_lvl (quad_lvl),
      .bits     (demap)
   );

   fsk_group_seq #(.ASYNC_RST(ASYNC_RST)) seq_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_start (frame_start),
      .sym_stb     (sym_stb),
      .rate_dbl    (rate_dbl),
      .load        (load),
      .grp_vld     (grp_vld)
   );

   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      fsk_pair_reg #(.ASYNC_RST(ASYNC_RST)) pair_i (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (frame_start),
         .load  (load[p]),
         .d     (demap),
         .q     (held[p])
      );
   end

   assign ph_a = held[0].hi;
   assign ph_b = held[0].lo;
   assign ph_c = held[1].hi;
   assign ph_d = held[1].lo;

endmodule

// File: rtl/fsk_phase_split_chk.sv
module fsk_phase_split_chk #(
   parameter int SYM_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_start,
   input logic             sym_stb,
   input logic [SYM_W-1:0] sym,
   input logic             rate_dbl,
   input logic             quad_lvl,
   input logic             ph_a,
   input logic             ph_b,
   input logic             ph_c,
   input logic             ph_d,
   input logic             grp_vld
);

   a_r5_vld_needs_stb: assert property (@(posedge clk) disable iff (!rst_n)
      grp_vld |-> ($past(sym_stb) && !$past(frame_start)));

   a_r9_frame_clears: assert property (@(posedge clk) disable iff (!rst_n)
      $past(frame_start) |-> ({ph_a, ph_b, ph_c, ph_d, grp_vld} == 5'b0));

   a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(sym_stb) && !$past(frame_start)) |->
         ($stable({ph_a, ph_b, ph_c, ph_d}) && !grp_vld));

   a_r2_first_bit_norm: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sym_stb) && !$past(frame_start) && !$past(rate_dbl)) |->
         (ph_a == ($past(sym) < 2'd2)));

   a_r8_first_bit_dbl: assert property (@(posedge clk) disable iff (!rst_n)
      (grp_vld && $past(rate_dbl)) |-> (ph_c == ($past(sym) < 2'd2)));

   a_r4_two_level_b: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sym_stb) && !$past(rate_dbl) && !$past(quad_lvl)) |-> !ph_b);

endmodule

bind fsk_phase_split fsk_phase_split_chk #(.SYM_W(SYM_W)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .sym_stb     (sym_stb),
   .sym         (sym),
   .rate_dbl    (rate_dbl),
   .quad_lvl    (quad_lvl),
   .ph_a        (ph_a),
   .ph_b        (ph_b),
   .ph_c        (ph_c),
   .ph_d        (ph_d),
   .grp_vld     (grp_vld)
);

// File: tb/fsk_phase_split_tb_top.sv
`timescale 1ns/1ps
module fsk_phase_split_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_start = 1'b0;
   logic       sym_stb = 1'b0;
   logic [1:0] sym = 2'd0;
   logic       rate_dbl = 1'b0;
   logic       quad_lvl = 1'b0;
   logic       ph_a, ph_b, ph_c, ph_d, grp_vld;

   int n_vec  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   fsk_phase_split dut_i (
      .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .sym_stb(sym_stb),
      .sym(sym), .rate_dbl(rate_dbl), .quad_lvl(quad_lvl),
      .ph_a(ph_a), .ph_b(ph_b), .ph_c(ph_c), .ph_d(ph_d), .grp_vld(grp_vld)
   );

   // Vector layout: [14:11] req no. | [10] frame_start | [9] strobe | [8:7] symbol
   //                [6] double rate | [5] four level | [4:1] expected A,B,C,D | [0] expected valid
   localparam int NV = 25;
   localparam logic [14:0] VEC [NV] = '{
      {4'd9,  1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 4'b0000, 1'b0}, // R9 start frame
      {4'd2,  1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 4'b1000, 1'b1}, // R2 R4 R5
      {4'd2,  1'b0, 1'b1, 2'd2, 1'b0, 1'b0, 4'b0000, 1'b1}, // R2
      {4'd4,  1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 4'b1000, 1'b1}, // R4
      {4'd6,  1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 4'b0000, 1'b1}, // R6
      {4'd10, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 4'b0000, 1'b0}, // R10
      {4'd3,  1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 4'b1100, 1'b1}, // R3
      {4'd3,  1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 4'b1000, 1'b1}, // R3
      {4'd3,  1'b0, 1'b1, 2'd2, 1'b0, 1'b1, 4'b0000, 1'b1}, // R3
      {4'd3,  1'b0, 1'b1, 2'd3, 1'b0, 1'b1, 4'b0100, 1'b1}, // R3 R6
      {4'd5,  1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 4'b0100, 1'b0}, // R5 R10
      {4'd9,  1'b1, 1'b0, 2'd0, 1'b1, 1'b1, 4'b0000, 1'b0}, // R9
      {4'd7,  1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 4'b1100, 1'b0}, // R7
      {4'd10, 1'b0, 1'b0, 2'd2, 1'b1, 1'b1, 4'b1100, 1'b0}, // R10
      {4'd8,  1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 4'b1101, 1'b1}, // R8
      {4'd7,  1'b0, 1'b1, 2'd2, 1'b1, 1'b1, 4'b0001, 1'b0}, // R7
      {4'd8,  1'b0, 1'b1, 2'd1, 1'b1, 1'b1, 4'b0010, 1'b1}, // R8
      {4'd9,  1'b1, 1'b0, 2'd0, 1'b1, 1'b0, 4'b0000, 1'b0}, // R9
      {4'd7,  1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 4'b1000, 1'b0}, // R7 R4
      {4'd8,  1'b0, 1'b1, 2'd3, 1'b1, 1'b0, 4'b1000, 1'b1}, // R8 R4
      {4'd7,  1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 4'b1000, 1'b0}, // R7
      {4'd8,  1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 4'b1010, 1'b1}, // R8
      {4'd9,  1'b1, 1'b1, 2'd0, 1'b1, 1'b1, 4'b0000, 1'b0}, // R9 strobe discarded
      {4'd9,  1'b0, 1'b1, 2'd3, 1'b1, 1'b1, 4'b0100, 1'b0}, // R9 tracking cleared
      {4'd8,  1'b0, 1'b1, 2'd0, 1'b1, 1'b1, 4'b0111, 1'b1}  // R8
   };

   task automatic check(input int req, input logic [4:0] exp);
      logic [4:0] act;
      act = {ph_a, ph_b, ph_c, ph_d, grp_vld};
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d: abcd_vld actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic drive(input logic fs, input logic stb, input logic [1:0] s,
                        input logic dbl, input logic quad);
      @(negedge clk);
      frame_start = fs; sym_stb = stb; sym = s; rate_dbl = dbl; quad_lvl = quad;
      @(posedge clk);
      #1;
   endtask

   initial begin
      // R1: outputs are cleared while reset is held
      repeat (3) @(posedge clk);
      #1;
      check(1, 5'b00000);
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 1'b0, 2'd0, 1'b0, 1'b0);
      check(1, 5'b00000); // R1 first cycle out of reset

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][10], VEC[i][9], VEC[i][8:7], VEC[i][6], VEC[i][5]);
         check(int'(VEC[i][14:11]), VEC[i][4:0]);
      end

      // R5: back-to-back strobes at the normal rate give a valid on every cycle
      drive(1'b1, 1'b0, 2'd0, 1'b0, 1'b1);
      drive(1'b0, 1'b1, 2'd2, 1'b0, 1'b1);
      check(5, 5'b00001);
      drive(1'b0, 1'b1, 2'd0, 1'b0, 1'b1);
      check(5, 5'b11001);
      drive(1'b0, 1'b0, 2'd0, 1'b0, 1'b1);
      check(5, 5'b11000);

      // R1: a mid-frame reset clears the outputs and the even/odd tracking
      drive(1'b1, 1'b0, 2'd0, 1'b1, 1'b1);
      drive(1'b0, 1'b1, 2'd0, 1'b1, 1'b1);
      check(7, 5'b11000);
      @(negedge clk);
      sym_stb = 1'b0;
      rst_n = 1'b0;
      #1;
      check(1, 5'b00000);
      @(negedge clk);
      rst_n = 1'b1;
      drive(1'b0, 1'b1, 2'd3, 1'b1, 1'b1);
      check(1, 5'b01000); // R1 next symbol lands on A/B with no valid

      @(negedge clk);
      sym_stb = 1'b0;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      #1000000;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule